// File: doc/BRIEF.md
# Time-Base Interval Timer with Watchdog

The block is a free-running binary prescaler driven by the main clock. It advances once every two clock cycles. Four of its stages can be picked as the source of a periodic interrupt. Each rising transition of the picked stage latches a sticky request flag. The flag reaches the interrupt line only while the interrupt enable is high. Software acknowledges a request by pulsing the flag-clear input. It can also restart the whole chain with the counter-clear input.

The top stage of the same chain also clocks a watchdog. The watchdog stays idle until software first pulses its kick input, and from then on it cannot be switched off except by a system reset. If no kick arrives before the second top-stage event, the watchdog raises a reset request for a single cycle. The default sizing is a 21-bit chain with taps at bit indices 11, 13, 16 and 20. At a 12.5 MHz clock this gives intervals of about 0.66 ms, 2.6 ms, 21 ms and 335 ms, and a watchdog timeout between one and two 335 ms periods.

All pins are plain control and status signals. There is no streamed data, so the block has no valid/ready handshake.

Top module: `timebase_wdt`

## Requirements
- R1: While reset is held and right after it, `irq_flag_o`, `irq_o` and `wdt_rst_o` are all 0.
- R2: The chain counts every second clock. `ival_sel_i` values 0, 1, 2, 3 select tap bit indices TAP0..TAP3. With counting started by reset or counter-clear, tap index t first rises 2^(t+1) clocks later and then every 2^(t+2) clocks. The flag is visible in the cycle after that edge.
- R3: A rising edge of the selected tap sets `irq_flag_o`. The flag then stays 1 until it is cleared.
- R4: `irq_o` is 1 exactly when `irq_flag_o` is 1 and `irq_en_i` is 1.
- R5: `flag_clr_i` drops the flag at the next edge. If a tap edge falls in the same cycle, the set wins and the flag stays 1.
- R6: `cnt_clr_i` zeroes the whole chain at the next edge, and counting then restarts as after reset. That edge never counts as a tap event, for either the flag or the watchdog.
- R7: A change of `ival_sel_i` takes effect in the same cycle. Only edges of the tap selected at that moment set the flag.
- R8: Before the first `wdt_kick_i` pulse, `wdt_rst_o` stays 0 however many top-tap events occur.
- R9: After a kick, `wdt_rst_o` pulses on the second top-tap (TAP3) event that follows the most recent kick. The pulse shows in the same cycle a TAP3-selected flag would set.
- R10: Once kicked, the watchdog keeps running until system reset. Kicking in the same cycle as a top-tap event discards that event, so kicks spaced closer than one top-tap period keep `wdt_rst_o` at 0.
- R11: Each `wdt_rst_o` pulse lasts exactly one cycle. No further pulse follows until the watchdog is kicked again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| ival_sel_i | input | 2 | Interval tap select, 0..3 |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle strobe that clears the request flag |
| cnt_clr_i | input | 1 | One-cycle strobe that zeroes the prescaler chain |
| wdt_kick_i | input | 1 | Watchdog start / restart strobe |
| irq_flag_o | output | 1 | Sticky interval request flag |
| irq_o | output | 1 | Interrupt request (flag gated by enable) |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
On every cycle the assertions check these local rules:
- at most one tap edge fires at a time;
- the chain advances on the right phase and empties on a clear;
- a selected edge sets the flag, and a lone clear drops it;
- the watchdog pulse is single-cycle, never appears while the watchdog is idle, follows a top-tap event, and is suppressed by a kick.

Only the bench's scenarios can show the absolute spacing of tap events in clock cycles, since that spacing spans hundreds of cycles. The same holds for the position of the watchdog pulse on the second top event after a kick, and for the counting restart after a chain clear.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int NUM_TAPS = 4;
  localparam int SEL_W    = $clog2(NUM_TAPS);
  typedef logic [SEL_W-1:0] tap_sel_t;
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler
  import tbt_pkg::*;
#(
  parameter int CNT_W = 21,
  parameter int TAP_BIT [NUM_TAPS] = '{11, 13, 16, 20}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tick_o
);
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  // a tap rises when the counter steps from (2^t - 1) to 2^t in its low t+1 bits
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << (TAP_BIT[g] + 1)) - 64'd1);
    localparam logic [CNT_W-1:0] PATT = CNT_W'((64'd1 << TAP_BIT[g]) - 64'd1);
    assign tick_o[g] = phase_q && !clr_i && ((cnt_q & MASK) == PATT);
  end

  assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tick_o));
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && phase_q) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  assert_hold_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !phase_q) |=> (cnt_q == $past(cnt_q)));
  assert_chain_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !phase_q));
endmodule

// File: rtl/tbt_irq_flag.sv
module tbt_irq_flag
  import tbt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] tick_i,
  input  tap_sel_t            sel_i,
  input  logic                en_i,
  input  logic                clr_i,
  output logic                flag_o,
  output logic                irq_o
);
  logic hit;
  assign hit = tick_i[sel_i];

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (hit)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & en_i;

  assert_set_on_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_o);
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> !flag_o);
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !hit) |=> !flag_o);
endmodule

// File: rtl/tbt_watchdog.sv
module tbt_watchdog #(
  parameter int EXPIRE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic tick_i,
  output logic rst_o
);
  localparam int WC_W = $clog2(EXPIRE_TICKS + 1);
  localparam logic [WC_W-1:0] LAST = WC_W'(EXPIRE_TICKS);

  logic            run_q;
  logic [WC_W-1:0] wc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      wc_q  <= '0;
      rst_o <= 1'b0;
    end else begin
      rst_o <= 1'b0;
      if (kick_i) begin
        run_q <= 1'b1;
        wc_q  <= '0;
      end else if (run_q && tick_i && wc_q != LAST) begin
        wc_q <= wc_q + 1'b1;
        if (wc_q == LAST - 1'b1) rst_o <= 1'b1;
      end
    end
  end

  assert_pulse_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |=> !rst_o);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !rst_o);
  assert_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> $past(tick_i));
  assert_kick_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !rst_o);
  assert_no_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);
endmodule

// File: rtl/timebase_wdt.sv
module timebase_wdt
  import tbt_pkg::*;
#(
  parameter int CNT_W = 21,
  parameter int TAP0  = 11,
  parameter int TAP1  = 13,
  parameter int TAP2  = 16,
  parameter int TAP3  = 20,
  parameter int WDT_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ival_sel_i,
  input  logic       irq_en_i,
  input  logic       flag_clr_i,
  input  logic       cnt_clr_i,
  input  logic       wdt_kick_i,
  output logic       irq_flag_o,
  output logic       irq_o,
  output logic       wdt_rst_o
);
  localparam int TAPS [NUM_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

  logic [NUM_TAPS-1:0] tick;

  tbt_prescaler #(.CNT_W(CNT_W), .TAP_BIT(TAPS)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr_i),
    .tick_o (tick)
  );

  tbt_irq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .sel_i  (tap_sel_t'(ival_sel_i)),
    .en_i   (irq_en_i),
    .clr_i  (flag_clr_i),
    .flag_o (irq_flag_o),
    .irq_o  (irq_o)
  );

  tbt_watchdog #(.EXPIRE_TICKS(WDT_TICKS)) u_wdt (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (wdt_kick_i),
    .tick_i (tick[NUM_TAPS-1]),
    .rst_o  (wdt_rst_o)
  );
endmodule

// File: tb/sim_timebase_wdt.sv
module sim_timebase_wdt;
  localparam int BT [4] = '{1, 3, 5, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic en = 1'b0, fclr = 1'b0, cclr = 1'b0, kick = 1'b0;
  logic flag, irq, wrst;

  always #5 clk = ~clk;

  timebase_wdt #(.CNT_W(8), .TAP0(BT[0]), .TAP1(BT[1]), .TAP2(BT[2]), .TAP3(BT[3])) u0 (
    .clk(clk), .rst_n(rst_n), .ival_sel_i(sel), .irq_en_i(en),
    .flag_clr_i(fclr), .cnt_clr_i(cclr), .wdt_kick_i(kick),
    .irq_flag_o(flag), .irq_o(irq), .wdt_rst_o(wrst)
  );

  int errors = 0, checks = 0, pulses = 0;
  string tag_f = "R1", tag_w = "R1";

  // expected-value model built from R2/R3/R5/R6/R9..R11
  int e = 0, m_wc = 0;
  bit m_flag = 0, m_run = 0, m_rst = 0;

  function automatic bit tap_event(int edge_no, int t);
    return (edge_no % 2 == 0) && (((edge_no / 2) % (1 << (t + 1))) == (1 << t));
  endfunction

  always @(posedge clk) begin
    bit ev, evtop;
    if (!rst_n) begin
      e = 0; m_flag = 0; m_run = 0; m_rst = 0; m_wc = 0;
    end else begin
      ev    = !cclr && tap_event(e + 1, BT[sel]);
      evtop = !cclr && tap_event(e + 1, BT[3]);
      e = cclr ? 0 : e + 1;
      if (ev) m_flag = 1; else if (fclr) m_flag = 0;
      m_rst = 0;
      if (kick) begin m_run = 1; m_wc = 0; end
      else if (m_run && evtop && m_wc < 2) begin
        m_wc++;
        if (m_wc == 2) m_rst = 1;
      end
    end
  end

  task automatic check(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check(flag, m_flag, tag_f, "irq_flag_o");
    check(irq, m_flag & en, "R4", "irq_o");
    check(wrst, m_rst, tag_w, "wdt_rst_o");
    if (wrst) pulses++;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(flag, 0, "R1", "flag in reset");
    check(irq, 0, "R1", "irq in reset");
    check(wrst, 0, "R1", "wdt in reset");
    rst_n = 1'b1; en = 1'b1;
    cyc();
    check(flag, 0, "R1", "flag after reset");

    // R2: first rise of each tap, counted from a chain clear; R8: watchdog idle
    tag_f = "R2"; tag_w = "R8";
    for (int s = 0; s < 4; s++) begin
      int n;
      sel = 2'(s); cclr = 1; fclr = 1;
      cyc();
      cclr = 0; fclr = 0;
      n = 0;
      while (!flag && n < 2000) begin cyc(); n++; end
      check(n == (2 << BT[s]), 1, "R2", $sformatf("first rise tap%0d after %0d", s, n));
    end
    repeat (1500) cyc();
    check(pulses == 0, 1, "R8", "no pulse before first kick");

    // R5: clear held high, set wins in same cycle
    tag_f = "R5"; sel = 2'd0; fclr = 1;
    for (int i = 0; i < 80; i++) begin en = 1'($urandom_range(0, 1)); cyc(); end
    fclr = 0;

    // R7: fast select changes
    tag_f = "R7";
    for (int i = 0; i < 2000; i++) begin
      cyc();
      if ($urandom_range(0, 5) == 0) sel = 2'($urandom_range(0, 3));
      fclr = ($urandom_range(0, 3) == 0);
    end
    fclr = 0;

    // R6: frequent chain clears
    tag_f = "R6"; sel = 2'd1;
    for (int i = 0; i < 2000; i++) begin
      cyc();
      cclr = ($urandom_range(0, 19) == 0);
      fclr = ($urandom_range(0, 7) == 0);
    end
    cclr = 0; fclr = 0;

    // R9 / R11: single kick then let it expire
    tag_w = "R9"; pulses = 0;
    kick = 1; cyc(); kick = 0;
    repeat (1800) cyc();
    check(pulses == 1, 1, "R11", $sformatf("pulse count %0d after one kick", pulses));

    // R10: kicks closer than a top period keep it quiet
    tag_w = "R10"; pulses = 0;
    for (int i = 0; i < 3000; i++) begin
      kick = (i % 400 == 0);
      cyc();
    end
    kick = 0;
    check(pulses == 0, 1, "R10", $sformatf("pulse count %0d with regular kicks", pulses));

    // R3 mixed random traffic
    tag_f = "R3"; tag_w = "R9";
    for (int i = 0; i < 12000; i++) begin
      cyc();
      kick = ($urandom_range(0, 299) == 0);
      cclr = ($urandom_range(0, 499) == 0);
      fclr = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 39) == 0) sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) en = ~en;
    end
    kick = 0; cclr = 0; fclr = 0;
    cyc();
    finish_run();
  end
endmodule